// File: doc/BRIEF.md
# Watchdog Timer with Undriven-Input Disable

This block supervises software activity through a single watchdog line. Firmware must change the level of that line, either rising or falling, often enough. If a full window of timebase ticks passes with no such change, the block pulls its active-low timeout flag down. The window length is a parameter counted in ticks. A typical window is 1.6 s, which is 1600 ticks of a 1 ms timebase.

Counting is held at zero in two cases: while the supervisor's reset is active, and while the watchdog line is flagged as undriven. When reset is released and the line is driven again, counting starts from zero. The flag also reports a low supply. Whenever supply-good is low, the flag goes low, whatever the timer holds. If the watchdog line is left undriven on purpose, the timer is disabled and the flag turns into a pure low-supply indicator.

The watchdog level is synchronized into the clock domain. Each change of level is held in a latch until the next tick uses it. A pulse that rises and falls again between two ticks therefore still counts as activity.

Top module: `wdog_float_mon`

## Requirements
- R1: With the line driven, reset inactive and supply good, each tick without a pending level change advances the window count by one. On the tick that brings the count to TIMEOUT_TICKS, `wdo_n` goes low one clock later.
- R2: After TIMEOUT_TICKS-1 quiet ticks, `wdo_n` is still high.
- R3: A rising or a falling change of the synchronized level restarts the window. At the next tick the count returns to zero, and a low `wdo_n` returns high.
- R4: A pulse of one clock period (two level changes between ticks) is recorded and restarts the window exactly as a single change does.
- R5: While `sup_rst` is 1, the count is held at zero and the timeout is cleared. With supply good, `wdo_n` is high from the next clock.
- R6: While `wd_float` is 1, the count is held at zero and the timeout is cleared. Level changes seen during that time are discarded.
- R7: After `sup_rst` and `wd_float` both return to 0, the timeout fires on exactly the TIMEOUT_TICKS-th tick.
- R8: When `supply_ok` is 0, `wdo_n` is 0 at the next clock, regardless of the timer. With `wd_float` at 1, this is the only way `wdo_n` goes low.
- R9: Once timed out, `wdo_n` stays low on further quiet ticks until a level change, `sup_rst` or `wd_float` clears it.
- R10: While `rst_n` is low, `wdo_n` is 1 and the count is zero. `wd_level` passes through SYNC_STAGES flip-flops before any change is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wd_level | input | 1 | Sampled watchdog line level, asynchronous to clk |
| wd_float | input | 1 | 1 when the watchdog line is undriven |
| sup_rst | input | 1 | Active-high reset from the reset generator |
| supply_ok | input | 1 | 1 while the supply is above threshold |
| tick | input | 1 | One-clock timebase pulse |
| wdo_n | output | 1 | Active-low timeout / low-supply flag |

## Verification
The assertions check, on every cycle:
- a low supply forces the flag low on the next clock;
- either hold input clears the count and raises the flag;
- the count stays within its bound and changes only on a tick or a hold;
- a recorded level change zeroes the count at the tick.

The exact boundary between TIMEOUT_TICKS-1 and TIMEOUT_TICKS quiet ticks can only be shown by the bench scenarios. The same holds for:
- capture of a one-clock pulse through the synchronizer;
- loss of level changes that occur while the line is undriven;
- restart of the window after a hold is released.

// File: rtl/wdm_pkg.sv
package wdm_pkg;

  // Control bundle handed from the top to the window counter.
  typedef struct packed {
    logic hold;       // reset active or line undriven
    logic tick;       // timebase sample
    logic edge_pend;  // a level change waits to be consumed
  } wdm_ctl_t;

  function automatic int unsigned wdm_cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/wdm_sync_edge.sv
module wdm_sync_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  input  logic hold,
  input  logic tick,
  output logic edge_pend
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   latch_q;
  logic                   latch_d;
  logic                   edge_now;

  // Synchronizer chain, one flop per stage.
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= 1'b0;
        else        sync_q[s] <= level_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= 1'b0;
        else        sync_q[s] <= sync_q[s-1];
      end
    end
  end

  assign edge_now = sync_q[LAST] ^ prev_q;

  // The latch keeps a change until the next tick, and is dropped while held.
  always_comb begin
    latch_d = latch_q;
    if (hold || tick) latch_d = 1'b0;
    else if (edge_now) latch_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= sync_q[LAST];
      latch_q <= latch_d;
    end
  end

  assign edge_pend = !hold && (latch_q || edge_now);

endmodule

// File: rtl/wdm_window_ctr.sv
module wdm_window_ctr
  import wdm_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 1600,
  localparam int unsigned CNT_W = wdm_cnt_width(TIMEOUT_TICKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wdm_ctl_t         ctl,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expired_q,
  output logic             expired_d
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_TICKS);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = ctl.hold || ctl.tick;

  always_comb begin
    cnt_d     = cnt_q;
    expired_d = expired_q;
    if (ctl.hold) begin
      cnt_d     = '0;
      expired_d = 1'b0;
    end else if (ctl.tick) begin
      if (ctl.edge_pend) begin
        cnt_d     = '0;
        expired_d = 1'b0;
      end else if (!expired_q) begin
        cnt_d     = cnt_q + 1'b1;
        expired_d = (cnt_q + 1'b1) == LIMIT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q     <= cnt_d;
      expired_q <= expired_d;
    end
  end

endmodule

// File: rtl/wdm_out_stage.sv
module wdm_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic expired_d,
  output logic wdo_n
);

  logic flag_d;

  assign flag_d = supply_ok && !expired_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdo_n <= 1'b1;
    else        wdo_n <= flag_d;
  end

endmodule

// File: rtl/wdog_float_mon.sv
module wdog_float_mon
  import wdm_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 1600,
  parameter int unsigned SYNC_STAGES   = 2,
  localparam int unsigned CNT_W = wdm_cnt_width(TIMEOUT_TICKS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_level,
  input  logic wd_float,
  input  logic sup_rst,
  input  logic supply_ok,
  input  logic tick,
  output logic wdo_n
);

  logic             hold;
  logic             edge_pend;
  logic [CNT_W-1:0] cnt_q;
  logic             expired_q;
  logic             expired_d;
  wdm_ctl_t         ctl;

  assign hold = sup_rst || wd_float;

  assign ctl.hold      = hold;
  assign ctl.tick      = tick;
  assign ctl.edge_pend = edge_pend;

  wdm_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (wd_level),
    .hold     (hold),
    .tick     (tick),
    .edge_pend(edge_pend)
  );

  wdm_window_ctr #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .cnt_q    (cnt_q),
    .expired_q(expired_q),
    .expired_d(expired_d)
  );

  wdm_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .supply_ok(supply_ok),
    .expired_d(expired_d),
    .wdo_n    (wdo_n)
  );

endmodule

// File: rtl/wdm_checker.sv
module wdm_checker
  import wdm_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 1600,
  localparam int unsigned CNT_W = wdm_cnt_width(TIMEOUT_TICKS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             hold,
  input logic             supply_ok,
  input logic             edge_pend,
  input logic [CNT_W-1:0] cnt_q,
  input logic             expired_q,
  input logic             wdo_n
);

  AST_SUPPLY_LOW_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !wdo_n); // R8

  AST_HOLD_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && supply_ok) |=> wdo_n); // R5

  AST_HOLD_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == '0 && !expired_q)); // R6

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(TIMEOUT_TICKS)); // R1

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !hold) |=> $stable(cnt_q)); // R1

  AST_EDGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && edge_pend && !hold) |=> (cnt_q == '0)); // R3

  AST_EXPIRED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    expired_q |-> !wdo_n); // R9

endmodule

bind wdog_float_mon wdm_checker #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .hold     (hold),
  .supply_ok(supply_ok),
  .edge_pend(edge_pend),
  .cnt_q    (cnt_q),
  .expired_q(expired_q),
  .wdo_n    (wdo_n)
);

// File: tb/tb_wdog_float_mon.sv
module tb_wdog_float_mon;

  localparam int unsigned T = 8;

  logic clk;
  logic rst_n;
  logic wd_level;
  logic wd_float;
  logic sup_rst;
  logic supply_ok;
  logic tick;
  logic wdo_n;

  int checks;
  int errors;
  int mcnt;
  bit done;

  wdog_float_mon #(.TIMEOUT_TICKS(T), .SYNC_STAGES(2)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wd_level (wd_level),
    .wd_float (wd_float),
    .sup_rst  (sup_rst),
    .supply_ok(supply_ok),
    .tick     (tick),
    .wdo_n    (wdo_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit exp_flag(input int cnt, input bit sok);
    return sok && (cnt < int'(T));
  endfunction

  task automatic check(input string tag, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: wdo_n actual %0b expected %0b", tag, act, expv);
    end
  endtask

  // One window step: set the inputs, optionally change the level, then one tick.
  task automatic step(input bit tog, input bit pulse, input bit flt,
                      input bit rst, input bit sok, input string tag);
    bit    hold;
    string t;
    @(negedge clk);
    wd_float  = flt;
    sup_rst   = rst;
    supply_ok = sok;
    if (tog) wd_level = ~wd_level;
    else if (pulse) begin
      wd_level = ~wd_level;
      @(negedge clk);
      wd_level = ~wd_level;
    end
    repeat (5) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (3) @(negedge clk);
    hold = flt || rst;
    if (hold || tog || pulse) mcnt = 0;
    else if (mcnt < int'(T)) mcnt++;
    t = tag;
    if (t == "") begin
      if (!sok)               t = "R8";
      else if (rst)           t = "R5";
      else if (flt)           t = "R6";
      else if (tog || pulse)  t = "R3";
      else if (mcnt >= int'(T)) t = "R9";
      else                    t = "R1";
    end
    check(t, wdo_n, exp_flag(mcnt, sok));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4242));
    checks = 0; errors = 0; mcnt = 0; done = 0;
    rst_n = 1'b0; wd_level = 1'b0; wd_float = 1'b0; sup_rst = 1'b0;
    supply_ok = 1'b1; tick = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 reset state", wdo_n, 1'b1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 after release", wdo_n, 1'b1);

    // Window boundary.
    for (int i = 0; i < int'(T) - 1; i++) step(0, 0, 0, 0, 1, "");
    check("R2 one tick before timeout", wdo_n, 1'b1);
    step(0, 0, 0, 0, 1, "R1 timeout on last tick");
    step(0, 0, 0, 0, 1, "R9 stays low");
    step(0, 0, 0, 0, 1, "R9 stays low again");
    step(1, 0, 0, 0, 1, "R3 toggle restarts");

    // Short pulse.
    for (int i = 0; i < int'(T) - 1; i++) step(0, 0, 0, 0, 1, "");
    step(0, 1, 0, 0, 1, "R4 one-clock pulse restarts");
    for (int i = 0; i < int'(T) - 1; i++) step(0, 0, 0, 0, 1, "");
    check("R4 window counted from pulse", wdo_n, 1'b1);
    step(0, 0, 0, 0, 1, "R4 timeout after pulse window");

    // Undriven line and low-line behaviour.
    step(0, 0, 1, 0, 1, "R6 float clears timeout");
    for (int i = 0; i < int'(T) + 2; i++) step(0, 0, 1, 0, 1, "R6 float holds");
    step(1, 0, 1, 0, 1, "R6 toggle while float");
    step(0, 0, 1, 0, 0, "R8 low-line while float");
    step(0, 0, 1, 0, 1, "R8 supply back while float");
    for (int i = 0; i < int'(T) - 1; i++) step(0, 0, 0, 0, 1, "R7 counting after float");
    step(0, 0, 0, 0, 1, "R7 timeout after float release");

    // Supervisor reset.
    step(0, 0, 0, 1, 1, "R5 reset clears timeout");
    step(0, 0, 0, 1, 0, "R8 supply low during reset");
    for (int i = 0; i < int'(T) - 1; i++) step(0, 0, 0, 0, 1, "R7 counting after reset");
    step(0, 0, 0, 0, 1, "R7 timeout after reset release");

    // Asynchronous reset mid-timeout.
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 async reset raises flag", wdo_n, 1'b1);
    rst_n = 1'b1;
    mcnt = 0;

    // Constrained random mix.
    for (int i = 0; i < 300; i++) begin
      int r;
      bit tg, pl, fl, rs, sk;
      r  = int'($urandom_range(0, 99));
      tg = (r < 12);
      pl = (r >= 12 && r < 18);
      fl = ($urandom_range(0, 99) < 8);
      rs = ($urandom_range(0, 99) < 5);
      sk = ($urandom_range(0, 99) >= 6);
      step(tg, pl, fl, rs, sk, "");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule